// File: doc/BRIEF.md
# Direct-Mapped Cache Lookup with Strobe Gating

This block is a small direct-mapped cache. It has four lines of eight bytes each and is addressed by a 12-bit main-memory address. A requester selects the block with an active-low select and drives one of four active-low strobes: a byte read, a byte write, a whole-line fill and a valid-flag update. Every lookup compares the tag stored on the indexed line with the tag field of the address. The block reports the result on an active-low hit output. Byte reads and byte writes go ahead only when that comparison hits.

A line fill writes all eight byte columns of the indexed line from a 64-bit bus and stores the address tag in the same cycle. The valid flag is written by its own strobe. That strobe may be used alone or together with a fill, so the requester can validate or invalidate a line without touching its data. Which line to refill, how the fill data is fetched, and write-back policy are left to the requester. All writes take effect on the rising clock edge. The hit output and the read data are combinational on the current address and the stored state.

Top module: `dmStrobeCache`

## Requirements
- R1: The address splits as offset = addr[2:0] (byte column, byte 0 is blkData[7:0]), index = addr[4:3] (line), tag = addr[11:5].
- R2: While csN is 1, no strobe has any effect: no storage changes, hitN is 1 and rdByte is 0.
- R3: A lookup hits only when the indexed line's valid flag is 1 and its stored tag equals addr[11:5].
- R4: hitN is 0 when csN is 0 and the lookup hits, and 1 otherwise.
- R5: rdByte shows the byte at the offset of the indexed line only while csN=0, rdN=0 and the lookup hits; otherwise it is 0.
- R6: A byte write (csN=0, wrN=0) stores wrByte into the single column at the offset only on a hit; on a miss the stored data is unchanged.
- R7: A line fill (csN=0, blkWrN=0) writes all eight columns of the indexed line from blkData and stores addr[11:5] as that line's tag.
- R8: A valid update (csN=0, vldWrN=0) stores vldIn into the indexed line's valid flag, with or without a fill, and leaves the line's data unchanged.
- R9: Reset (rstN=0) clears every valid flag, so no lookup hits until a line is validated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low block select |
| rdN | input | 1 | Active-low byte read strobe |
| wrN | input | 1 | Active-low byte write strobe |
| blkWrN | input | 1 | Active-low whole-line fill strobe |
| vldWrN | input | 1 | Active-low valid-flag write strobe |
| addr | input | 12 | Main-memory address (tag, index, offset) |
| wrByte | input | 8 | Data for a byte write |
| blkData | input | 64 | Line fill data, byte 0 in bits [7:0] |
| vldIn | input | 1 | Value stored by a valid-flag write |
| hitN | output | 1 | Active-low hit indication |
| rdByte | output | 8 | Read data; 0 unless a hitting read |

## Verification
The assertions check the following on every cycle:
- a deselected block issues no internal strobe;
- at most one line matches;
- the read bus is zero without a read grant;
- a fill leaves both the tag and all eight bytes in place one cycle later;
- a valid update stores the requested value;
- the data array holds still whenever neither kind of write is granted.

Some behaviours only the bench's scenarios can show. These are the end-to-end behaviours across many cycles: a byte write on a miss changes nothing, an invalidated line keeps its data for a later revalidation, a valid line with a stale tag still misses, and reset drops every line back to a miss.

// File: rtl/cacheTypesPkg.sv
`timescale 1ns/1ps
package cacheTypesPkg;
  // Internal enables granted by the control to the storage
  typedef struct packed {
    logic rdEn;   // byte read, qualified by select and hit
    logic wrEn;   // byte write, qualified by select and hit
    logic blkEn;  // whole-line fill, qualified by select
    logic vldEn;  // valid-flag write, qualified by select
  } strobe_t;
endpackage

// File: rtl/cacheStrobeCtrl.sv
`timescale 1ns/1ps
module cacheStrobeCtrl
  import cacheTypesPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    rdN,
  input  logic    wrN,
  input  logic    blkWrN,
  input  logic    vldWrN,
  input  logic    lineHit,
  output strobe_t strb,
  output logic    hitN
);
  logic selected;

  always_comb begin
    selected   = ~csN;
    strb.rdEn  = selected & ~rdN & lineHit;
    strb.wrEn  = selected & ~wrN & lineHit;
    strb.blkEn = selected & ~blkWrN;
    strb.vldEn = selected & ~vldWrN;
    hitN       = ~(selected & lineHit);
  end

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (strb == '0 && hitN)); // R2

  AST_GRANT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn || strb.wrEn) |-> !hitN); // R4
endmodule

// File: rtl/cacheLineStore.sv
`timescale 1ns/1ps
module cacheLineStore
  import cacheTypesPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int BYTES = 1 << OFF_W,
  localparam int LINES = 1 << IDX_W,
  localparam int BLK_W = 8 * BYTES
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrByte,
  input  logic [BLK_W-1:0]  blkData,
  input  logic              vldIn,
  output logic              lineHit,
  output logic [7:0]        rdByte
);
  logic [OFF_W-1:0] offset;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tagIn;

  logic [LINES-1:0][TAG_W-1:0]      tagMem;
  logic [LINES-1:0]                 validMem;
  logic [LINES-1:0][BYTES-1:0][7:0] dataMem;

  logic [LINES-1:0] lineSel;
  logic [LINES-1:0] lineMatch;
  logic [BYTES-1:0] colEn;

  assign offset = addr[OFF_W-1:0];
  assign idx    = addr[OFF_W+IDX_W-1:OFF_W];
  assign tagIn  = addr[ADDR_W-1:OFF_W+IDX_W];

  // Line decode and per-line match
  for (genvar l = 0; l < LINES; l++) begin : gLine
    assign lineSel[l]   = (idx == IDX_W'(l));
    assign lineMatch[l] = lineSel[l] & validMem[l] & (tagMem[l] == tagIn);
  end
  assign lineHit = |lineMatch;

  // Column enables: every column during a fill, else the offset column
  for (genvar c = 0; c < BYTES; c++) begin : gCol
    assign colEn[c] = strb.blkEn | (strb.wrEn & (offset == OFF_W'(c)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validMem <= '0;
      tagMem   <= '0;
      dataMem  <= '0;
    end else begin
      for (int l = 0; l < LINES; l++) begin
        if (lineSel[l]) begin
          if (strb.blkEn) tagMem[l] <= tagIn;
          if (strb.vldEn) validMem[l] <= vldIn;
          for (int c = 0; c < BYTES; c++) begin
            if (colEn[c])
              dataMem[l][c] <= strb.blkEn ? blkData[8*c +: 8] : wrByte;
          end
        end
      end
    end
  end

  assign rdByte = strb.rdEn ? dataMem[idx][offset] : 8'h00;

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lineMatch)); // R3

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |-> (rdByte == 8'h00)); // R5

  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrEn && !strb.blkEn) |=> $stable(dataMem)); // R6

  AST_FILL_TAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.blkEn |=> (tagMem[$past(idx)] == $past(tagIn))); // R7

  AST_FILL_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.blkEn |=> (dataMem[$past(idx)] == $past(blkData))); // R7

  AST_VALID_STORED: assert property (@(posedge clk) disable iff (!rstN)
    strb.vldEn |=> (validMem[$past(idx)] == $past(vldIn))); // R8
endmodule

// File: rtl/dmStrobeCache.sv
`timescale 1ns/1ps
module dmStrobeCache
  import cacheTypesPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 2,
  localparam int BLK_W = 8 * (1 << OFF_W)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              blkWrN,
  input  logic              vldWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrByte,
  input  logic [BLK_W-1:0]  blkData,
  input  logic              vldIn,
  output logic              hitN,
  output logic [7:0]        rdByte
);
  strobe_t strb;
  logic    lineHit;

  cacheStrobeCtrl uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .blkWrN(blkWrN), .vldWrN(vldWrN), .lineHit(lineHit),
    .strb(strb), .hitN(hitN)
  );

  cacheLineStore #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrByte(wrByte),
    .blkData(blkData), .vldIn(vldIn), .lineHit(lineHit), .rdByte(rdByte)
  );
endmodule

// File: tb/dmStrobeCache_test.sv
`timescale 1ns/1ps
module dmStrobeCache_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rdN = 1'b1, wrN = 1'b1, blkWrN = 1'b1, vldWrN = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0]  wrByte = '0;
  logic [63:0] blkData = '0;
  logic        vldIn = 1'b0;
  logic        hitN;
  logic [7:0]  rdByte;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dmStrobeCache uut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .blkWrN(blkWrN), .vldWrN(vldWrN), .addr(addr), .wrByte(wrByte),
    .blkData(blkData), .vldIn(vldIn), .hitN(hitN), .rdByte(rdByte)
  );

  typedef struct packed {
    logic [4:0]  ctl;     // {csN, rdN, wrN, blkWrN, vldWrN}
    logic [11:0] a;
    logic [7:0]  wb;
    logic [63:0] bd;
    logic        vi;
    logic        expHitN;
    logic [7:0]  expRd;
    logic [7:0]  req;     // requirement number for messages
  } vec_t;

  localparam logic [63:0] FILL = 64'h8877665544332211;
  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{5'b00111, 12'h0A9, 8'h00, 64'h0,  1'b0, 1'b1, 8'h00, 8'd9}, // R9 cold miss
    '{5'b01100, 12'h0A8, 8'h00, FILL,   1'b1, 1'b1, 8'h00, 8'd7}, // R7 fill+validate line 1
    '{5'b00111, 12'h0A9, 8'h00, 64'h0,  1'b0, 1'b0, 8'h22, 8'd5}, // R5 R1 byte 1
    '{5'b00111, 12'h0AF, 8'h00, 64'h0,  1'b0, 1'b0, 8'h88, 8'd1}, // R1 byte 7
    '{5'b10111, 12'h0A9, 8'h00, 64'h0,  1'b0, 1'b1, 8'h00, 8'd2}, // R2 deselected read
    '{5'b00111, 12'h1A9, 8'h00, 64'h0,  1'b0, 1'b1, 8'h00, 8'd3}, // R3 tag mismatch
    '{5'b01011, 12'h1AA, 8'hEE, 64'h0,  1'b0, 1'b1, 8'h00, 8'd6}, // R6 miss write
    '{5'b00111, 12'h0AA, 8'h00, 64'h0,  1'b0, 1'b0, 8'h33, 8'd6}, // R6 unchanged
    '{5'b01011, 12'h0AA, 8'hEE, 64'h0,  1'b0, 1'b0, 8'h00, 8'd6}, // R6 hit write
    '{5'b00111, 12'h0AA, 8'h00, 64'h0,  1'b0, 1'b0, 8'hEE, 8'd6}, // R6 new byte
    '{5'b00111, 12'h0AB, 8'h00, 64'h0,  1'b0, 1'b0, 8'h44, 8'd6}, // R6 neighbour intact
    '{5'b01110, 12'h0A8, 8'h00, 64'h0,  1'b0, 1'b0, 8'h00, 8'd8}, // R8 invalidate alone
    '{5'b00111, 12'h0A9, 8'h00, 64'h0,  1'b0, 1'b1, 8'h00, 8'd8}, // R8 now misses
    '{5'b01110, 12'h0B0, 8'h00, 64'h0,  1'b1, 1'b1, 8'h00, 8'd8}, // R8 validate line 2
    '{5'b00111, 12'h0B0, 8'h00, 64'h0,  1'b0, 1'b1, 8'h00, 8'd3}, // R3 valid, stale tag
    '{5'b01110, 12'h0A8, 8'h00, 64'h0,  1'b1, 1'b1, 8'h00, 8'd8}, // R8 revalidate line 1
    '{5'b00111, 12'h0AA, 8'h00, 64'h0,  1'b0, 1'b0, 8'hEE, 8'd8}, // R8 data kept
    '{5'b11001, 12'h0AA, 8'h55, ~64'h0, 1'b1, 1'b1, 8'h00, 8'd2}, // R2 deselected writes
    '{5'b00111, 12'h0AA, 8'h00, 64'h0,  1'b0, 1'b0, 8'hEE, 8'd2}  // R2 nothing changed
  };

  task automatic checkOut(input logic expH, input logic [7:0] expR,
                          input int req, input string what);
    compared++;
    if (hitN !== expH || rdByte !== expR) begin
      mismatched++;
      $display("FAIL R%0d %s: hitN=%b rdByte=%h expected hitN=%b rdByte=%h",
               req, what, hitN, rdByte, expH, expR);
    end
  endtask

  task automatic idle();
    {csN, rdN, wrN, blkWrN, vldWrN} = 5'b11111;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 checkOut(1'b1, 8'h00, 9, "reset state R9");
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {csN, rdN, wrN, blkWrN, vldWrN} = TBL[i].ctl;
      addr = TBL[i].a; wrByte = TBL[i].wb; blkData = TBL[i].bd; vldIn = TBL[i].vi;
      #1 checkOut(TBL[i].expHitN, TBL[i].expRd, int'(TBL[i].req), $sformatf("vector %0d", i));
    end
    // R4: a hit with no strobe still reports hitN=0
    @(negedge clk); idle(); csN = 1'b0; addr = 12'h0AA;
    #1 checkOut(1'b0, 8'h00, 4, "hit without strobe R4");
    // R7: refill line 1 with a new tag, old tag then misses
    @(negedge clk); idle(); csN = 1'b0; blkWrN = 1'b0; addr = 12'h1A8;
    blkData = 64'hF0E0D0C0B0A09080;
    @(negedge clk); idle(); csN = 1'b0; rdN = 1'b0; addr = 12'h1AE;
    #1 checkOut(1'b0, 8'hE0, 7, "refill new tag R7");
    @(negedge clk); addr = 12'h0AE;
    #1 checkOut(1'b1, 8'h00, 7, "old tag replaced R7");
    // R9: reset mid-run drops all lines
    @(negedge clk); idle(); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; csN = 1'b0; rdN = 1'b0; addr = 12'h1AE;
    #1 checkOut(1'b1, 8'h00, 9, "miss after reset R9");
    @(negedge clk); idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule